// File: doc/BRIEF.md
# Escaping Packet Frame Transmitter

This block turns a payload of up to 255 bytes into an outgoing framed packet and hands it out one byte at a time to a serial transmitter. A packet is requested with a one-cycle `start` pulse and a length. The payload bytes are pulled one after another from an input stream. The block sends two start-of-frame bytes, then the payload, then a checksum, then one end-of-frame byte. An escape byte is placed in front of any payload or checksum byte that collides with one of the three control values.

Both streams use valid/ready. A byte moves only in a cycle where its valid and ready are both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values. Payload bytes are taken only while `in_ready` is high. `in_ready` is high only in the cycles where the block waits for its next payload byte, and the output is idle in those cycles. `in_valid` may drop at any time, and the block waits for it. Once the end byte has been accepted, `done` pulses high for one cycle and `busy` falls.

Top module: `pkt_frame_tx`

## Requirements
- R1: While reset is held and right after it, `out_valid`, `in_ready`, `busy` and `done` are low.
- R2: The accepted output bytes of a packet are, in order: 0x0F, 0x0F, the payload field, the checksum field, 0x04.
- R3: An escape byte 0x05 is sent right before any payload byte whose value is 0x0F, 0x04 or 0x05. The byte that follows an accepted escape is always a control value.
- R4: The checksum is the two's complement of the low 8 bits of the sum of the raw payload bytes. Escape and framing bytes are not part of the sum.
- R5: A checksum equal to 0x0F, 0x04 or 0x05 is also preceded by an escape byte 0x05.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R7: Exactly `pkt_len` payload bytes are taken per packet. `in_ready` is high only while `busy` is high and `out_valid` is low.
- R8: A `start` pulse while `busy` is high is ignored, and `pkt_len` is sampled only when a packet is accepted. Changing it mid-packet has no effect.
- R9: A length of zero produces exactly 0x0F, 0x0F, 0x00, 0x04.
- R10: `done` is high for exactly one cycle. That cycle is the one right after the end byte is accepted, and `busy` is low in it.
- R11: A full 255-byte payload is framed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Packet request pulse, taken only when idle |
| pkt_len | input | LEN_W | Payload length, sampled with an accepted start |
| in_data | input | 8 | Payload byte stream data |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Block takes a payload byte this cycle |
| out_data | output | 8 | Outgoing framed byte |
| out_valid | output | 1 | Outgoing byte present |
| out_ready | input | 1 | Transmitter accepts the outgoing byte |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse after the end byte is accepted |

## Verification
Every output comes from a register. The first start byte is valid in the cycle after `start` is sampled. Each later byte appears in the cycle after the previous one is accepted, with one extra idle output cycle for each payload byte that is fetched. `done` appears exactly one cycle after the end byte is accepted. The bench drives and samples on the falling edge. It records a byte as accepted when valid and ready are both high at that point, because the byte then moves on the next rising edge. It checks `done` at the next falling edge after the end byte is recorded. It checks held data at the falling edge after each stalled one.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_CTRL = 3;
  localparam logic [BYTE_W-1:0] FRAME_OPEN  = 8'h0F;
  localparam logic [BYTE_W-1:0] FRAME_CLOSE = 8'h04;
  localparam logic [BYTE_W-1:0] ESC_MARK    = 8'h05;
  localparam logic [BYTE_W-1:0] CTRL_SET [NUM_CTRL] = '{FRAME_OPEN, FRAME_CLOSE, ESC_MARK};

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPEN1,
    ST_OPEN2,
    ST_FETCH,
    ST_DESC,
    ST_DBYTE,
    ST_CESC,
    ST_CBYTE,
    ST_CLOSE
  } tx_state_e;
endpackage

// File: rtl/pkt_frame_ctrl_match.sv
module pkt_frame_ctrl_match
  import pkt_frame_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output logic              is_ctrl
);
  logic [NUM_CTRL-1:0] hit;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_cmp
    assign hit[g] = (byte_in == CTRL_SET[g]);
  end

  assign is_ctrl = |hit;
endmodule

// File: rtl/pkt_frame_sum.sv
module pkt_frame_sum #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [BW-1:0] add_val,
  output logic [BW-1:0] cks
);
  logic [BW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (add_en) acc_q <= acc_q + add_val;
  end

  assign cks = (~acc_q) + BW'(1);
endmodule

// File: rtl/pkt_frame_seq.sv
module pkt_frame_seq
  import pkt_frame_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_is_ctrl,
  input  logic [BYTE_W-1:0] cks,
  input  logic              cks_is_ctrl,
  input  logic              out_ready,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  output logic              busy,
  output logic              done,
  output logic              sum_clr,
  output logic              sum_add
);
  tx_state_e         st_q, st_d;
  logic [LEN_W-1:0]  len_q, len_d, cnt_q, cnt_d;
  logic [BYTE_W-1:0] obyte_q, obyte_d, hold_q, hold_d;
  logic              done_d;
  logic              fire_o, fire_i, last_data;

  assign out_valid = (st_q != ST_IDLE) && (st_q != ST_FETCH);
  assign in_ready  = (st_q == ST_FETCH);
  assign busy      = (st_q != ST_IDLE);
  assign out_data  = obyte_q;
  assign fire_o    = out_valid && out_ready;
  assign fire_i    = in_valid && in_ready;
  assign last_data = (cnt_q == len_q);
  assign sum_add   = fire_i;
  assign sum_clr   = (st_q == ST_IDLE) && start;

  always_comb begin
    st_d    = st_q;
    len_d   = len_q;
    cnt_d   = cnt_q;
    obyte_d = obyte_q;
    hold_d  = hold_q;
    done_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        len_d   = pkt_len;
        cnt_d   = '0;
        obyte_d = FRAME_OPEN;
        st_d    = ST_OPEN1;
      end
      ST_OPEN1: if (fire_o) begin
        obyte_d = FRAME_OPEN;
        st_d    = ST_OPEN2;
      end
      ST_OPEN2, ST_DBYTE: if (fire_o) begin
        if (last_data) begin
          if (cks_is_ctrl) begin
            obyte_d = ESC_MARK;
            hold_d  = cks;
            st_d    = ST_CESC;
          end else begin
            obyte_d = cks;
            st_d    = ST_CBYTE;
          end
        end else begin
          st_d = ST_FETCH;
        end
      end
      ST_FETCH: if (fire_i) begin
        cnt_d = cnt_q + LEN_W'(1);
        if (in_is_ctrl) begin
          obyte_d = ESC_MARK;
          hold_d  = in_data;
          st_d    = ST_DESC;
        end else begin
          obyte_d = in_data;
          st_d    = ST_DBYTE;
        end
      end
      ST_DESC: if (fire_o) begin
        obyte_d = hold_q;
        st_d    = ST_DBYTE;
      end
      ST_CESC: if (fire_o) begin
        obyte_d = hold_q;
        st_d    = ST_CBYTE;
      end
      ST_CBYTE: if (fire_o) begin
        obyte_d = FRAME_CLOSE;
        st_d    = ST_CLOSE;
      end
      ST_CLOSE: if (fire_o) begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      obyte_q <= '0;
      hold_q  <= '0;
      done    <= 1'b0;
    end else begin
      st_q    <= st_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
      obyte_q <= obyte_d;
      hold_q  <= hold_d;
      done    <= done_d;
    end
  end
endmodule

// File: rtl/pkt_frame_tx.sv
module pkt_frame_tx
  import pkt_frame_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              busy,
  output logic              done
);
  logic              in_is_ctrl, cks_is_ctrl, sum_clr, sum_add;
  logic [BYTE_W-1:0] cks;

  pkt_frame_ctrl_match u_in_match (.byte_in(in_data), .is_ctrl(in_is_ctrl));
  pkt_frame_ctrl_match u_ck_match (.byte_in(cks),     .is_ctrl(cks_is_ctrl));

  pkt_frame_sum #(.BW(BYTE_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add_en(sum_add),
    .add_val(in_data), .cks(cks)
  );

  pkt_frame_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_len(pkt_len),
    .in_data(in_data), .in_valid(in_valid), .in_is_ctrl(in_is_ctrl),
    .cks(cks), .cks_is_ctrl(cks_is_ctrl), .out_ready(out_ready),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .busy(busy), .done(done), .sum_clr(sum_clr), .sum_add(sum_add)
  );
endmodule

// File: rtl/pkt_frame_tx_chk.sv
module pkt_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       busy,
  input logic       done
);
  logic esc_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) esc_seen_q <= 1'b0;
    else if (out_valid && out_ready)
      esc_seen_q <= !esc_seen_q && (out_data == 8'h05);
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7
  fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy && !out_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !out_valid);

  // R3
  esc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_seen_q |-> out_valid &&
      (out_data == 8'h0F || out_data == 8'h04 || out_data == 8'h05));
endmodule

bind pkt_frame_tx pkt_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .busy(busy), .done(done)
);

// File: tb/pkt_frame_tx_test.sv
module pkt_frame_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] pkt_len = '0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       busy;
  logic       done;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pkt_frame_tx #(.LEN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_len(pkt_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .busy(busy), .done(done)
  );

  // {len, base, step, ready_mode, input_mode}
  localparam logic [31:0] VEC [0:7] = '{
    {8'd4,   8'h10, 8'h01, 4'd0, 4'd0},
    {8'd6,   8'h02, 8'h01, 4'd1, 4'd0},
    {8'd3,   8'h0F, 8'h00, 4'd2, 4'd1},
    {8'd1,   8'hFB, 8'h00, 4'd0, 4'd0},
    {8'd1,   8'hFC, 8'h00, 4'd1, 4'd1},
    {8'd1,   8'hF1, 8'h00, 4'd0, 4'd0},
    {8'd255, 8'h00, 8'h01, 4'd0, 4'd0},
    {8'd0,   8'h00, 8'h00, 4'd2, 4'd0}
  };

  logic [7:0] pay [0:255];
  logic [7:0] exp_b [0:600];
  logic [7:0] got_b [0:600];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic bit ctl(input logic [7:0] b);
    return b == 8'h0F || b == 8'h04 || b == 8'h05;
  endfunction

  task automatic run_pkt(input int n, input logic [7:0] base, input logic [7:0] step,
                         input int rm, input int im, input bit mid, input string tag);
    int exp_n, got_n, idx, cyc, eof_cyc, done_cnt, done_cyc;
    logic [7:0] sum, ck, stall_byte;
    bit stall_prev, mid_done, finished, mism;
    exp_n = 0; sum = 8'h00;
    exp_b[exp_n++] = 8'h0F;
    exp_b[exp_n++] = 8'h0F;
    for (int i = 0; i < n; i++) begin
      pay[i] = base + 8'(i) * step;
      if (ctl(pay[i])) exp_b[exp_n++] = 8'h05;
      exp_b[exp_n++] = pay[i];
      sum = sum + pay[i];
    end
    ck = 8'h00 - sum;
    if (ctl(ck)) exp_b[exp_n++] = 8'h05;
    exp_b[exp_n++] = ck;
    exp_b[exp_n++] = 8'h04;

    @(negedge clk);
    pkt_len = 8'(n); start = 1'b1;
    got_n = 0; idx = 0; cyc = 0; eof_cyc = -10; done_cnt = 0; done_cyc = -1;
    stall_prev = 0; mid_done = 0; finished = 0; stall_byte = '0;
    while (!finished && cyc < 5000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (done) begin
        done_cnt++; done_cyc = cyc; finished = 1;
        // R10
        chk(!busy, "R10", busy, 0);
      end
      if (stall_prev) begin
        // R6
        chk(out_valid && out_data == stall_byte, "R6", out_data, stall_byte);
      end
      in_valid = (idx < n) && (im == 0 || cyc % 2 == 0);
      if (idx < n) in_data = pay[idx];
      if (in_valid && in_ready) idx++;
      out_ready = (rm == 0) ? 1'b1 : (rm == 1) ? cyc[0] : (cyc % 3 == 0);
      if (out_valid && out_ready) begin
        got_b[got_n] = out_data;
        if (got_n + 1 == exp_n) eof_cyc = cyc;
        if (got_n < 600) got_n++;
      end
      stall_prev = out_valid && !out_ready;
      stall_byte = out_data;
      if (mid && !mid_done && got_n == 3) begin
        // R8: new request and length change while busy
        start = 1'b1; pkt_len = 8'd9; mid_done = 1;
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R10
    chk(!done && done_cnt == 1, "R10", done_cnt, 1);
    chk(done_cyc == eof_cyc + 1, "R10", done_cyc, eof_cyc + 1);
    chk(got_n == exp_n, tag, got_n, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got_b[i] !== exp_b[i]) begin
        if (!mism) chk(0, tag, got_b[i], exp_b[i]);
        mism = 1;
      end
    if (!mism) chk(1, tag, 0, 0);
    // R7
    chk(idx == n, "R7", idx, n);
    chk(!busy && !in_ready, "R7", in_ready, 0);
  endtask

  initial begin
    #(4ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!out_valid && !in_ready && !busy && !done, "R1", {out_valid, in_ready, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_ready && !busy && !done, "R1", {out_valid, in_ready, busy, done}, 0);

    for (int v = 0; v < 8; v++) begin
      logic [31:0] e;
      e = VEC[v];
      // R2 R3 R4 R5 R9 R11 covered through the vector set
      run_pkt(int'(e[31:24]), e[23:16], e[15:8], int'(e[7:4]), int'(e[3:0]), 0,
              v == 1 ? "R3" : v == 2 ? "R3" : v >= 3 && v <= 5 ? "R5" :
              v == 6 ? "R11" : v == 7 ? "R9" : "R2");
    end

    // R4: sum wraps, no control collisions
    run_pkt(5, 8'hC8, 8'h11, 1, 1, 0, "R4");
    // R8: start ignored mid-packet, length latched
    run_pkt(2, 8'h30, 8'h01, 2, 0, 1, "R8");
    // R9: zero length with steady ready
    run_pkt(0, 8'h00, 8'h00, 0, 0, 0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule